// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces one column address per beat of an SDRAM read or write burst. A one-cycle start strobe captures the start column, the burst length code, the ordering mode and the access type. On the following cycle the first beat appears on the output. One further beat follows on every cycle until the burst is complete. Every beat stays inside the aligned block of columns whose size equals the burst length. The ordering mode picks how the low column bits move inside that block: a wrapping count, or the start bits XORed with the beat index.

A controller uses the outputs to drive the column field of each column access. The beat stream has no back-pressure. Once a burst starts, beats advance every cycle and the consumer must take each one while `beat_valid` is high. The only way to change the stream is a new start strobe, which cuts off the running burst. A global mode flag can force every write burst down to a single beat while reads keep the programmed length.

Top module: `sdram_burst_colgen`

## Requirements
- R1: The burst length code selects the number of valid beats: 2'b00 gives 1 beat, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8.
- R2: The cycle after `start` is sampled high, `beat_valid` is high and `col_addr` equals the captured `start_col`.
- R3: During a burst of length L, every bit of `col_addr` above the lowest log2(L) bits keeps the value it had in `start_col`.
- R4: With `interleave` low (sequential order), beat i carries low bits equal to (start low bits + i) modulo L.
- R5: With `interleave` high, beat i carries low bits equal to the start low bits XOR i. For example, length 8 from column 2 gives 2,3,0,1,6,7,4,5.
- R6: When `single_write` is high, a burst started with `is_write` high is one beat long. A read keeps the programmed length. When `single_write` is low, writes keep the programmed length.
- R7: A `start` that arrives while a burst is active abandons that burst. Beat 0 of the new burst appears on the next cycle.
- R8: `last_beat` is high only on the final beat of a burst. If no new start arrives, `beat_valid` is low on the cycle after that beat.
- R9: While reset is asserted and after its release with no start, `beat_valid` and `last_beat` are low.
- R10: A burst of length 1 gives exactly one beat, at the start column, in both ordering modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new burst with the fields below |
| start_col | input | COL_W | First column of the burst |
| blen_code | input | 2 | Burst length code, 1 << code beats |
| interleave | input | 1 | 1 = XOR ordering, 0 = wrapping count |
| is_write | input | 1 | 1 = write burst, 0 = read burst |
| single_write | input | 1 | Force write bursts to one beat |
| col_addr | output | COL_W | Column for the current beat |
| beat_valid | output | 1 | A beat is present this cycle |
| last_beat | output | 1 | This beat ends the burst |

## Verification
The bench sweeps every start low-bit value against every length, both orderings and every access/mode combination. Upper address bits are set to non-zero patterns, so a generator that carried into the upper bits instead of wrapping would corrupt `col_addr` on the beats after the block boundary. A design that swapped the two orderings, or added where it should XOR, would break the mismatching beats, such as beat 2 from column 2 at length 8. Restart in the middle of a burst and single-beat write forcing are each exercised directly. An off-by-one in the beat count shows up as a missing or extra `beat_valid` or a misplaced `last_beat`.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  // log2 of the largest burst (8 beats)
  localparam int BEAT_W = 3;
  localparam int CODE_W = 2;

  typedef enum logic {
    ORD_WRAP = 1'b0,
    ORD_XOR  = 1'b1
  } order_e;
endpackage

// File: rtl/colgen_len.sv
module colgen_len
  import colgen_pkg::*;
(
  input  logic [CODE_W-1:0] blen_code,
  input  logic              is_write,
  input  logic              single_write,
  output logic [BEAT_W-1:0] len_mask
);
  logic              force_one;
  logic [BEAT_W-1:0] prog_mask;

  assign force_one = single_write & is_write;

  // prog_mask = (1 << code) - 1, built bit by bit
  for (genvar b = 0; b < BEAT_W; b++) begin : g_mask
    assign prog_mask[b] = (int'(blen_code) > b);
  end

  assign len_mask = force_one ? '0 : prog_mask;
endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
  import colgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BEAT_W-1:0] len_mask_in,
  output logic              active,
  output logic [BEAT_W-1:0] beat_cnt,
  output logic [BEAT_W-1:0] len_mask_q,
  output logic              at_end
);
  assign at_end = active && (beat_cnt == len_mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      beat_cnt   <= '0;
      len_mask_q <= '0;
    end else if (start) begin
      active     <= 1'b1;
      beat_cnt   <= '0;
      len_mask_q <= len_mask_in;
    end else if (active) begin
      if (beat_cnt == len_mask_q) begin
        active <= 1'b0;
      end else begin
        beat_cnt <= beat_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0]  base_col,
  input  logic [BEAT_W-1:0] len_mask,
  input  logic [BEAT_W-1:0] beat_cnt,
  input  order_e            order,
  output logic [COL_W-1:0]  col
);
  logic [BEAT_W-1:0] low_wrap;
  logic [BEAT_W-1:0] low_xor;
  logic [BEAT_W-1:0] low_sel;

  assign low_wrap = base_col[BEAT_W-1:0] + beat_cnt;
  assign low_xor  = base_col[BEAT_W-1:0] ^ beat_cnt;
  assign low_sel  = (order == ORD_XOR) ? low_xor : low_wrap;

  // bits inside the burst block follow the order, bits outside stay
  for (genvar b = 0; b < BEAT_W; b++) begin : g_low
    assign col[b] = len_mask[b] ? low_sel[b] : base_col[b];
  end
  assign col[COL_W-1:BEAT_W] = base_col[COL_W-1:BEAT_W];
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       blen_code,
  input  logic             interleave,
  input  logic             is_write,
  input  logic             single_write,
  output logic [COL_W-1:0] col_addr,
  output logic             beat_valid,
  output logic             last_beat
);
  logic [COL_W-1:0]  base_q;
  order_e            order_q;
  logic [BEAT_W-1:0] mask_next;
  logic [BEAT_W-1:0] mask_q;
  logic [BEAT_W-1:0] cnt_q;
  logic              active_q;
  logic              end_q;

  colgen_len u_len (
    .blen_code    (blen_code),
    .is_write     (is_write),
    .single_write (single_write),
    .len_mask     (mask_next)
  );

  colgen_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .len_mask_in (mask_next),
    .active      (active_q),
    .beat_cnt    (cnt_q),
    .len_mask_q  (mask_q),
    .at_end      (end_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORD_WRAP;
    end else if (start) begin
      base_q  <= start_col;
      order_q <= interleave ? ORD_XOR : ORD_WRAP;
    end
  end

  colgen_addr #(.COL_W(COL_W)) u_addr (
    .base_col (base_q),
    .len_mask (mask_q),
    .beat_cnt (cnt_q),
    .order    (order_q),
    .col      (col_addr)
  );

  assign beat_valid = active_q;
  assign last_beat  = end_q;
endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [1:0]       blen_code,
  input logic             is_write,
  input logic             single_write,
  input logic [COL_W-1:0] col_addr,
  input logic             beat_valid,
  input logic             last_beat
);
  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (beat_valid && col_addr == $past(start_col)));

  // R8
  last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> beat_valid);

  // R8
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> !beat_valid);

  // R1
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !last_beat && !start) |=> beat_valid);

  // R3
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !last_beat && !start) |=> $stable(col_addr[COL_W-1:3]));

  // R6
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && single_write && is_write) |=> last_beat);

  // R10
  len_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && blen_code == 2'b00) |=> last_beat);
endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .start_col    (start_col),
  .blen_code    (blen_code),
  .is_write     (is_write),
  .single_write (single_write),
  .col_addr     (col_addr),
  .beat_valid   (beat_valid),
  .last_beat    (last_beat)
);

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;
  localparam int COL_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [1:0]       blen_code = '0;
  logic             interleave = 1'b0;
  logic             is_write = 1'b0;
  logic             single_write = 1'b0;
  logic [COL_W-1:0] col_addr;
  logic             beat_valid;
  logic             last_beat;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .blen_code(blen_code), .interleave(interleave), .is_write(is_write),
    .single_write(single_write), .col_addr(col_addr),
    .beat_valid(beat_valid), .last_beat(last_beat)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] s, int len,
                                               bit il, int i);
    int m;
    int low;
    m   = len - 1;
    low = il ? ((int'(s) ^ i) & m) : ((int'(s) + i) & m);
    return (s & ~COL_W'(m)) | COL_W'(low);
  endfunction

  // start burst: drive at negedge, first beat visible at next negedge
  task automatic launch(logic [COL_W-1:0] c, logic [1:0] code, bit il,
                        bit wr, bit sw);
    start = 1'b1; start_col = c; blen_code = code;
    interleave = il; is_write = wr; single_write = sw;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_burst(logic [COL_W-1:0] c, logic [1:0] code, bit il,
                           bit wr, bit sw, string req);
    int len;
    len = (sw && wr) ? 1 : (1 << code);
    launch(c, code, il, wr, sw);
    for (int i = 0; i < len; i++) begin
      check({req, " valid"}, 32'(beat_valid), 32'd1);
      check({req, " col"}, 32'(col_addr), 32'(exp_col(c, len, il, i)));
      check({"R8 last"}, 32'(last_beat), 32'(i == len - 1));
      @(negedge clk);
    end
    check("R8 idle after burst", 32'(beat_valid), 32'd0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: during reset
    check("R9 valid in reset", 32'(beat_valid), 32'd0);
    check("R9 last in reset", 32'(last_beat), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 valid after reset", 32'(beat_valid), 32'd0);
    check("R9 last after reset", 32'(last_beat), 32'd0);

    // R1 R2 R3 R4 R5 R6 R10: exhaustive sweep of low bits, lengths, modes
    for (int lo = 0; lo < 8; lo++) begin
      for (int code = 0; code < 4; code++) begin
        for (int il = 0; il < 2; il++) begin
          for (int k = 0; k < 4; k++) begin
            logic [COL_W-1:0] c;
            c = COL_W'((lo * 37 + code * 64 + k * 128) & 'h1F8) | COL_W'(lo);
            run_burst(c, 2'(code), il[0], k[0], k[1],
                      il ? "R5 xor order" : "R4 wrap order");
          end
        end
      end
    end

    // R5: named example, length 8 from column 2
    begin
      int seq8 [8] = '{2, 3, 0, 1, 6, 7, 4, 5};
      launch(COL_W'(2), 2'b11, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 8; i++) begin
        check("R5 example", 32'(col_addr), 32'(seq8[i]));
        @(negedge clk);
      end
    end

    // R6: read in single-write mode keeps full length
    run_burst(COL_W'(9'h1A5), 2'b10, 1'b0, 1'b0, 1'b1, "R6 read keeps length");
    // R10: length 1 both orders
    run_burst(COL_W'(9'h0F3), 2'b00, 1'b0, 1'b0, 1'b0, "R10 len1 wrap");
    run_burst(COL_W'(9'h0F3), 2'b00, 1'b1, 1'b0, 1'b0, "R10 len1 xor");

    // R7: restart after three beats of an 8-beat burst
    launch(COL_W'(9'h104), 2'b11, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    check("R7 before abort", 32'(col_addr), 32'(9'h106));
    start = 1'b1; start_col = COL_W'(9'h05D); blen_code = 2'b01;
    interleave = 1'b1; is_write = 1'b0; single_write = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check("R7 new beat0 col", 32'(col_addr), 32'(9'h05D));
    check("R7 new beat0 last", 32'(last_beat), 32'd0);
    @(negedge clk);
    check("R7 new beat1 col", 32'(col_addr), 32'(9'h05C));
    check("R7 new beat1 last", 32'(last_beat), 32'd1);
    @(negedge clk);
    check("R7 ends after new", 32'(beat_valid), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule